// File: doc/BRIEF.md
# Dual-Screen Colour Blender

This block turns a pair of palette indices into one output pixel. Each cycle it takes an index for the main screen and one for the sub screen. It looks both up at the same time in an internal 256-entry colour table that has two read ports and one write port. It then merges the two colours channel by channel. The merge is an addition or a subtraction, with optional halving, saturation at the top of the range and clamping at zero. Window selection and layer priority are resolved upstream. They arrive here as a finished main index, a sub index and the identity of the layer that won the main screen.

A host port writes the colour table and a small bank of control registers. The control registers hold the blend mode, the set of layers for which blending is allowed, and a fixed sub-screen index that can stand in for the sub screen. The datapath is a two-stage pipeline: one stage for the table read and one for the arithmetic. A valid flag travels alongside the data, so a new pixel can be accepted every cycle.

Top module: `cmb_blend`

## Requirements
- R1: A colour word is 16 bits: red in bits 14:10, green in bits 9:5, blue in bits 4:0. Bit 15 is ignored. The pixel output carries red in bits 14:10, green in 9:5 and blue in 4:0.
- R2: A host write with address bit 8 clear stores the data into colour entry address[7:0]. A write with bit 8 set goes to the control register selected by address[3:0]. Offset 0x9 holds the fixed sub index in bits 7:0. Offset 0xA holds the blend control: bit 7 selects subtract, bit 6 selects halving, and bits 4:0 enable blending per winning layer. Offset 0xB bit 1 turns the fixed sub index on. Writes to any other offset have no effect on the output.
- R3: After reset, the valid output is low and the pixel output is zero. A pixel accepted at clock edge k appears with its valid flag after edge k+2. While no valid result arrives, the pixel output holds its last value.
- R4: Index 0 on either screen is transparent. If exactly one screen is transparent, the other screen's colour is output unaltered. If both are transparent, the output is 0.
- R5: The winning-layer code selects a bit of the blend enable field: 0 to 3 select layers 1 to 4 (bits 0 to 3), and 4 selects objects (bit 4). Codes 5 to 7 never blend. When the selected bit is clear, the main colour passes unchanged.
- R6: In addition mode without halving, each channel is main plus sub, and any sum above 31 gives 31.
- R7: In subtract mode without halving, each channel is main minus sub, and a negative result gives 0.
- R8: With halving on, addition gives (main+sub)/2 rounded down. Subtraction gives (main−sub)/2 rounded down, or 0 if the difference is negative.
- R9: With the fixed sub index on, the stored index replaces the incoming sub index, and it follows the same rules. A stored index of 0 makes the sub screen transparent.
- R10: Both table reads happen in the same cycle, so a stream of pixels with a different main and sub index every cycle gives one correct result per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 9 | Host address; bit 8 picks registers over colour table |
| host_wdata | input | 16 | Host write data |
| pix_valid_i | input | 1 | Input pixel valid |
| main_idx | input | 8 | Main-screen palette index, 0 = transparent |
| sub_idx | input | 8 | Sub-screen palette index, 0 = transparent |
| main_top | input | 3 | Code of the layer that won the main screen |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_rgb | output | 15 | Blended pixel, red/green/blue |

## Verification
The bound checker checks four things on every cycle: the two-cycle valid latency, the output holding when no result arrives, black output for a doubly transparent input, and pass-through of the main colour when blending is gated off. It also checks that addition never lowers a main channel and subtraction never raises one. Exact channel values cannot be checked cycle by cycle; only the bench scenarios show them. These cover saturation at 31, the clamp at 0, halving of both signs, the fixed sub index (including a stored 0), winning-layer codes with no enable bit, and ignored register offsets. The dense back-to-back stream is what shows both read ports serving distinct indices in the same cycle.

// File: rtl/cmb_pkg.sv
package cmb_pkg;

   // control register offsets, decoded from the low host address bits
   typedef enum logic [3:0] {
      CREG_FIXIDX = 4'h9,
      CREG_BLEND  = 4'hA,
      CREG_SUBSEL = 4'hB
   } creg_e;

   // blend control bit positions inside CREG_BLEND
   localparam int unsigned BL_SUB_BIT  = 7;
   localparam int unsigned BL_HALF_BIT = 6;
   // fixed-sub enable bit inside CREG_SUBSEL
   localparam int unsigned FIX_ON_BIT  = 1;

   typedef struct packed {
      logic main_clr;
      logic sub_clr;
      logic blend;
      logic sub_mode;
      logic half;
   } s1_flags_t;

endpackage

// File: rtl/cmb_pal_ram.sv
module cmb_pal_ram #(
   parameter int unsigned AW  = 8,
   parameter int unsigned DW  = 16,
   parameter int unsigned NRD = 2
) (
   input  logic                    clk,
   input  logic                    we,
   input  logic [AW-1:0]           waddr,
   input  logic [DW-1:0]           wdata,
   input  logic [NRD-1:0][AW-1:0]  raddr,
   output logic [NRD-1:0][DW-1:0]  rdata
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   // one registered read per port, all ports see the same array
   for (genvar p = 0; p < NRD; p++) begin : g_rd
      always_ff @(posedge clk) begin
         rdata[p] <= mem[raddr[p]];
      end
   end
endmodule

// File: rtl/cmb_ctrl_regs.sv
module cmb_ctrl_regs
   import cmb_pkg::*;
#(
   parameter int unsigned IDX_W  = 8,
   parameter int unsigned WORD_W = 16,
   parameter int unsigned NSRC   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [3:0]        offs,
   input  logic [WORD_W-1:0] wdata,
   output logic [IDX_W-1:0]  fix_idx,
   output logic              fix_on,
   output logic              sub_mode,
   output logic              half,
   output logic [NSRC-1:0]   src_en
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fix_idx  <= '0;
         fix_on   <= 1'b0;
         sub_mode <= 1'b0;
         half     <= 1'b0;
         src_en   <= '0;
      end else if (we) begin
         case (creg_e'(offs))
            CREG_FIXIDX: fix_idx <= wdata[IDX_W-1:0];
            CREG_BLEND: begin
               sub_mode <= wdata[BL_SUB_BIT];
               half     <= wdata[BL_HALF_BIT];
               src_en   <= wdata[NSRC-1:0];
            end
            CREG_SUBSEL: fix_on <= wdata[FIX_ON_BIT];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/cmb_chan_math.sv
module cmb_chan_math #(
   parameter int unsigned CW = 5
) (
   input  logic [CW-1:0] a,
   input  logic [CW-1:0] b,
   input  logic          sub_mode,
   input  logic          half,
   output logic [CW-1:0] y
);
   logic [CW-1:0] b_op;
   logic [CW:0]   total;

   // subtraction reuses the adder: complemented operand plus carry-in
   always_comb begin
      b_op  = sub_mode ? ~b : b;
      total = {1'b0, a} + {1'b0, b_op} + {{CW{1'b0}}, sub_mode};
      if (sub_mode) begin
         if (!total[CW])  y = '0;
         else if (half)   y = {1'b0, total[CW-1:1]};
         else             y = total[CW-1:0];
      end else begin
         if (half)           y = total[CW:1];
         else if (total[CW]) y = '1;
         else                y = total[CW-1:0];
      end
   end
endmodule

// File: rtl/cmb_blend.sv
module cmb_blend
   import cmb_pkg::*;
#(
   parameter int unsigned CH_W   = 5,
   parameter int unsigned NCH    = 3,
   parameter int unsigned IDX_W  = 8,
   parameter int unsigned WORD_W = 16,
   parameter int unsigned NSRC   = 5,
   parameter int unsigned TOP_W  = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  host_we,
   input  logic [IDX_W:0]        host_addr,
   input  logic [WORD_W-1:0]     host_wdata,
   input  logic                  pix_valid_i,
   input  logic [IDX_W-1:0]      main_idx,
   input  logic [IDX_W-1:0]      sub_idx,
   input  logic [TOP_W-1:0]      main_top,
   output logic                  pix_valid_o,
   output logic [NCH*CH_W-1:0]   pix_rgb
);
   localparam int unsigned RGB_W = NCH * CH_W;

   initial begin
      if (CH_W < 2) $fatal(1, "CH_W too small");
      if (RGB_W > WORD_W) $fatal(1, "colour word too narrow for channels");
      if (NSRC > (1 << TOP_W)) $fatal(1, "TOP_W cannot code all sources");
      if (NSRC > 6) $fatal(1, "NSRC collides with mode bits");
   end

   // host decode
   logic pal_we, reg_we;
   assign pal_we = host_we && !host_addr[IDX_W];
   assign reg_we = host_we &&  host_addr[IDX_W];

   logic [IDX_W-1:0] fix_idx;
   logic             fix_on, sub_mode, half;
   logic [NSRC-1:0]  src_en;

   cmb_ctrl_regs #(.IDX_W(IDX_W), .WORD_W(WORD_W), .NSRC(NSRC)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .offs(host_addr[3:0]),
      .wdata(host_wdata), .fix_idx(fix_idx), .fix_on(fix_on),
      .sub_mode(sub_mode), .half(half), .src_en(src_en)
   );

   // stage 0: choose sub index, decide gating
   logic [IDX_W-1:0] sub_eff;
   logic             blend_hit;
   assign sub_eff = fix_on ? fix_idx : sub_idx;

   always_comb begin
      blend_hit = 1'b0;
      for (int s = 0; s < NSRC; s++) begin
         if (main_top == TOP_W'(s)) blend_hit = src_en[s];
      end
   end

   logic [1:0][IDX_W-1:0]  rd_addr;
   logic [1:0][WORD_W-1:0] rd_data;
   assign rd_addr[0] = main_idx;
   assign rd_addr[1] = sub_eff;

   cmb_pal_ram #(.AW(IDX_W), .DW(WORD_W), .NRD(2)) u_pal (
      .clk(clk), .we(pal_we), .waddr(host_addr[IDX_W-1:0]),
      .wdata(host_wdata), .raddr(rd_addr), .rdata(rd_data)
   );

   // stage 1: colours arrive from the table, flags registered alongside
   s1_flags_t  s1_f;
   logic       s1_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_f     <= '0;
      end else begin
         s1_valid      <= pix_valid_i;
         s1_f.main_clr <= (main_idx == '0);
         s1_f.sub_clr  <= (sub_eff == '0);
         s1_f.blend    <= blend_hit;
         s1_f.sub_mode <= sub_mode;
         s1_f.half     <= half;
      end
   end

   logic [RGB_W-1:0] s1_main, s1_sub, mixed;
   assign s1_main = rd_data[0][RGB_W-1:0];
   assign s1_sub  = rd_data[1][RGB_W-1:0];

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      cmb_chan_math #(.CW(CH_W)) u_math (
         .a(s1_main[c*CH_W +: CH_W]),
         .b(s1_sub[c*CH_W +: CH_W]),
         .sub_mode(s1_f.sub_mode),
         .half(s1_f.half),
         .y(mixed[c*CH_W +: CH_W])
      );
   end

   logic [RGB_W-1:0] result;
   always_comb begin
      unique case ({s1_f.main_clr, s1_f.sub_clr})
         2'b11:   result = '0;
         2'b10:   result = s1_sub;
         2'b01:   result = s1_main;
         default: result = s1_f.blend ? mixed : s1_main;
      endcase
   end

   // stage 2: output register
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pix_valid_o <= 1'b0;
         pix_rgb     <= '0;
      end else begin
         pix_valid_o <= s1_valid;
         if (s1_valid) pix_rgb <= result;
      end
   end
endmodule

module cmb_blend_chk #(
   parameter int unsigned CH_W  = 5,
   parameter int unsigned NCH   = 3,
   parameter int unsigned IDX_W = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 pix_valid_i,
   input logic [IDX_W-1:0]     main_idx,
   input logic [IDX_W-1:0]     sub_idx,
   input logic                 fix_on,
   input logic [IDX_W-1:0]     fix_idx,
   input logic                 s1_valid,
   input logic                 s1_main_clr,
   input logic                 s1_sub_clr,
   input logic                 s1_blend,
   input logic                 s1_sub_mode,
   input logic                 s1_half,
   input logic [NCH*CH_W-1:0]  s1_main,
   input logic                 pix_valid_o,
   input logic [NCH*CH_W-1:0]  pix_rgb
);
   logic both_clear_in;
   assign both_clear_in = pix_valid_i && (main_idx == '0) &&
                          ((fix_on ? fix_idx : sub_idx) == '0);

   logic s1_full;
   assign s1_full = s1_valid && !s1_main_clr && !s1_sub_clr && s1_blend;

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid_i |=> ##1 pix_valid_o); // R3
   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid_i |=> ##1 !pix_valid_o); // R3
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !s1_valid |=> $stable(pix_rgb)); // R3
   AST_BOTH_CLEAR_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
      both_clear_in |=> ##1 (pix_rgb == '0)); // R4
   AST_GATED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && !s1_main_clr && !s1_sub_clr && !s1_blend)
      |=> (pix_rgb == $past(s1_main))); // R5
   AST_ADD_NOT_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_full && !s1_sub_mode && !s1_half)
      |=> (pix_rgb[14:10] >= $past(s1_main[14:10])) &&
          (pix_rgb[9:5]   >= $past(s1_main[9:5])) &&
          (pix_rgb[4:0]   >= $past(s1_main[4:0]))); // R6
   AST_SUB_NOT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_full && s1_sub_mode)
      |=> (pix_rgb[14:10] <= $past(s1_main[14:10])) &&
          (pix_rgb[9:5]   <= $past(s1_main[9:5])) &&
          (pix_rgb[4:0]   <= $past(s1_main[4:0]))); // R7
endmodule

bind cmb_blend cmb_blend_chk #(.CH_W(CH_W), .NCH(NCH), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pix_valid_i(pix_valid_i),
   .main_idx(main_idx), .sub_idx(sub_idx), .fix_on(fix_on), .fix_idx(fix_idx),
   .s1_valid(s1_valid), .s1_main_clr(s1_f.main_clr), .s1_sub_clr(s1_f.sub_clr),
   .s1_blend(s1_f.blend), .s1_sub_mode(s1_f.sub_mode), .s1_half(s1_f.half),
   .s1_main(s1_main), .pix_valid_o(pix_valid_o), .pix_rgb(pix_rgb)
);

// File: tb/cmb_blend_bench.sv
module cmb_blend_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0;
   logic [8:0]  host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic        pix_valid_i = 1'b0;
   logic [7:0]  main_idx = '0;
   logic [7:0]  sub_idx = '0;
   logic [2:0]  main_top = '0;
   logic        pix_valid_o;
   logic [14:0] pix_rgb;

   always #5 clk = ~clk;

   cmb_blend u_cmb_blend (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .pix_valid_i(pix_valid_i), .main_idx(main_idx),
      .sub_idx(sub_idx), .main_top(main_top), .pix_valid_o(pix_valid_o),
      .pix_rgb(pix_rgb)
   );

   int n_chk = 0;
   int n_fail = 0;

   // bench-side model of the programmable state
   logic [15:0] m_pal [256];
   logic [7:0]  m_fix_idx = '0;
   logic        m_fix_on = 1'b0;
   logic        m_sub = 1'b0;
   logic        m_half = 1'b0;
   logic [4:0]  m_en = '0;

   typedef struct {
      logic [14:0] rgb;
      string       tag;
   } exp_t;
   exp_t exp_q[$];

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic int chan(input int a, input int b);
      int r;
      if (m_sub) begin
         r = a - b;
         if (r < 0) r = 0;
         else if (m_half) r = r / 2;
      end else begin
         r = a + b;
         if (m_half) r = r / 2;
         else if (r > 31) r = 31;
      end
      return r;
   endfunction

   function automatic logic [14:0] model(input logic [7:0] mi, input logic [7:0] si_in,
                                         input logic [2:0] top);
      logic [7:0]  si;
      logic [14:0] mc, sc;
      int r, g, b;
      si = m_fix_on ? m_fix_idx : si_in;
      mc = m_pal[mi][14:0];
      sc = m_pal[si][14:0];
      if (mi == 0 && si == 0) return 15'd0;
      if (mi == 0) return sc;
      if (si == 0) return mc;
      if (top > 3'd4 || !m_en[top]) return mc;
      r = chan(int'(mc[14:10]), int'(sc[14:10]));
      g = chan(int'(mc[9:5]), int'(sc[9:5]));
      b = chan(int'(mc[4:0]), int'(sc[4:0]));
      return {r[4:0], g[4:0], b[4:0]};
   endfunction

   // driver
   task automatic host_write(input logic [8:0] a, input logic [15:0] d);
      @(posedge clk); #1;
      pix_valid_i = 1'b0;
      host_we = 1'b1; host_addr = a; host_wdata = d;
      @(posedge clk); #1;
      host_we = 1'b0;
      if (!a[8]) m_pal[a[7:0]] = d;
      else begin
         case (a[3:0])
            4'h9: m_fix_idx = d[7:0];
            4'hA: begin m_sub = d[7]; m_half = d[6]; m_en = d[4:0]; end
            4'hB: m_fix_on = d[1];
            default: ;
         endcase
      end
   endtask

   task automatic send(input logic [7:0] mi, input logic [7:0] si,
                       input logic [2:0] top, input string tag);
      exp_t e;
      @(posedge clk); #1;
      pix_valid_i = 1'b1; main_idx = mi; sub_idx = si; main_top = top;
      e.rgb = model(mi, si, top);
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic idle(input int n);
      @(posedge clk); #1;
      pix_valid_i = 1'b0;
      repeat (n) @(posedge clk);
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && pix_valid_o) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R3: actual unexpected pixel %0h expected none", pix_rgb);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, {17'd0, pix_rgb}, {17'd0, e.rgb});
         end
      end
   end

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R3: actual watchdog expired expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [14:0] held;
      repeat (3) @(posedge clk);
      #1;
      check("R3 reset valid", {31'd0, pix_valid_o}, 32'd0);
      check("R3 reset pixel", {17'd0, pix_rgb}, 32'd0);
      rst_n = 1'b1;

      // colour table: pattern with bit 15 toggling (R1)
      for (int i = 0; i < 48; i++)
         host_write(9'(i), {i[0], 5'(i * 3), 5'(i * 7 + 2), 5'(31 - i)});
      host_write(9'd50, 16'hFFFF);                       // 31,31,31 with bit15 set
      host_write(9'd51, {1'b0, 5'd16, 5'd1, 5'd0});
      host_write(9'd52, {1'b0, 5'd2, 5'd20, 5'd31});
      host_write(9'd53, {1'b0, 5'd20, 5'd20, 5'd20});

      // R3 latency and hold, R1 format, R5 gated off (enable field zero)
      send(8'd53, 8'd52, 3'd0, "R5 gated pass");
      idle(0);
      @(negedge clk);
      check("R3 not yet valid", {31'd0, pix_valid_o}, 32'd0);
      @(negedge clk);
      check("R3 valid after two edges", {31'd0, pix_valid_o}, 32'd1);
      check("R1 format", {17'd0, pix_rgb}, {17'd0, 5'd20, 5'd20, 5'd20});
      held = pix_rgb;
      @(negedge clk);
      check("R3 valid drops", {31'd0, pix_valid_o}, 32'd0);
      check("R3 hold", {17'd0, pix_rgb}, {17'd0, held});
      idle(2);

      // R4 transparency
      send(8'd0, 8'd0, 3'd0, "R4 both clear");
      send(8'd0, 8'd51, 3'd0, "R4 main clear");
      host_write(9'h10A, 16'h001F);
      send(8'd51, 8'd0, 3'd0, "R4 sub clear");
      send(8'd50, 8'd0, 3'd1, "R1 bit15 ignored");
      // R6 saturation
      send(8'd50, 8'd51, 3'd0, "R6 add saturate");
      send(8'd52, 8'd51, 3'd4, "R6 add objects");
      send(8'd53, 8'd53, 3'd3, "R6 add layer4");
      // R5 codes beyond the objects never blend
      send(8'd52, 8'd51, 3'd5, "R5 code5 pass");
      send(8'd53, 8'd52, 3'd7, "R5 code7 pass");
      idle(3);
      host_write(9'h10A, 16'h0004);
      send(8'd53, 8'd52, 3'd2, "R5 enabled layer3");
      send(8'd53, 8'd52, 3'd1, "R5 disabled layer2");
      // R7 subtract, negative clamps
      host_write(9'h10A, 16'h009F);
      send(8'd53, 8'd51, 3'd0, "R7 sub");
      send(8'd51, 8'd52, 3'd0, "R7 sub clamp");
      send(8'd53, 8'd53, 3'd0, "R7 sub equal");
      // R8 halving
      host_write(9'h10A, 16'h00DF);
      send(8'd53, 8'd51, 3'd0, "R8 half sub");
      send(8'd51, 8'd52, 3'd0, "R8 half sub negative");
      host_write(9'h10A, 16'h005F);
      send(8'd50, 8'd50, 3'd0, "R8 half add max");
      send(8'd52, 8'd51, 3'd0, "R8 half add");
      // R2 ignored offsets and palette write at bit 8 clear
      host_write(9'h100, 16'hFFFF);
      host_write(9'h10F, 16'hFFFF);
      host_write(9'h10C, 16'h0000);
      send(8'd52, 8'd51, 3'd0, "R2 ignored offsets");
      host_write(9'd51, {1'b0, 5'd1, 5'd2, 5'd3});
      send(8'd52, 8'd51, 3'd0, "R2 entry rewrite");
      // R9 fixed sub index
      host_write(9'h10A, 16'h001F);
      host_write(9'h109, 16'h0032);
      host_write(9'h10B, 16'h0002);
      send(8'd52, 8'd0, 3'd0, "R9 fixed replaces clear sub");
      send(8'd51, 8'd53, 3'd0, "R9 fixed replaces sub");
      host_write(9'h109, 16'h0000);
      send(8'd51, 8'd53, 3'd0, "R9 fixed zero is clear");
      send(8'd0, 8'd53, 3'd0, "R9 fixed zero both clear");
      host_write(9'h10B, 16'h0000);
      idle(3);

      // R10 dense stream across modes
      for (int mode = 0; mode < 3; mode++) begin
         host_write(9'h10A, (mode == 0) ? 16'h001B : (mode == 1) ? 16'h0097 : 16'h00DF);
         for (int k = 0; k < 24; k++)
            send(8'((k * 5 + mode) % 48), 8'((k * 11 + 3) % 48), 3'(k % 8), "R10 stream");
         idle(3);
      end

      idle(4);
      check("R3 all results delivered", exp_q.size(), 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule